// File: doc/BRIEF.md
# Two-Way Set-Associative Write-Back Data Cache

This block sits between a CPU load/store unit and a line-oriented memory port. It keeps 64-byte lines in a two-way set-associative store. The set index comes from the address bits directly above the line offset. A load or store of 1, 2, 4, 8 or 16 bytes that hits completes with no memory traffic. A miss picks a victim way with a per-way least-recently-filled flag. If the victim holds modified data, the block first copies it back to memory. It then fetches the requested line and replays the access on it.

Each way keeps a 32-bit tag word. The physical tag sits above the index bits. Fixed low bits hold the modified (bit 6), present (bit 5), least-recently-filled (bit 4) and lock (bit 3) flags. Lines move to and from memory as four 16-byte beats. Each beat is a separate valid/ready handshake. Store data is merged byte by byte into the addressed 16-byte quadword. Load data is returned right-aligned.

Top module: `dc_two_way_cache`

## Requirements
- R1: An access hits when a way of the indexed set (index = addr[11:6] by default) is present and its tag equals the address bits above the index. Way 0 takes precedence over way 1. A hit raises `rsp_valid` with `rsp_hit`=1 in the cycle after acceptance and makes no memory transfer.
- R2: On a miss, the way refilled is the XOR of the two ways' least-recently-filled flags. Filling a way inverts that way's flag. Starting from reset, successive misses to one set therefore fill way 0, then way 1, then way 0 again. The response to a miss carries `rsp_hit`=0.
- R3: Before a refill, a victim that is both present and modified is written to memory as four write beats. The beats go to addresses {victim tag, index, beat[1:0], 4'b0} for beats 0..3, and the modified flag is then cleared. A victim that is clean or absent causes no write beat.
- R4: A refill issues four read beats to {request tag, index, beat[1:0], 4'b0}. Beat k supplies quadword k of the line. The way becomes present with its new tag.
- R5: A store sets the way's modified flag. Size code 0/1/2/3/4 means 1/2/4/8/16 bytes, and codes above 4 act as 4. The byte offset is addr[3:0] rounded down to the size. The low bytes of `req_wdata` replace those bytes of quadword addr[5:4], and every other byte is unchanged. A store response returns zero data.
- R6: A load returns the addressed bytes, zero-extended, in the low bits of `rsp_rdata`.
- R7: A request is accepted when `req_valid` is high and `busy` is low. After a miss is accepted, `busy` stays high until the cycle in which `rsp_valid` is high.
- R8: After reset every way is absent and both flags of each set are equal. `busy`, `rsp_valid` and `mem_valid` are low, and the first access to any set misses into way 0.
- R9: A memory beat transfers only when `mem_valid` and `mem_ready` are both high. While `mem_valid` is high and `mem_ready` is low, `mem_valid`, `mem_write` and `mem_addr` hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | CPU request present |
| req_write | input | 1 | 1 = store, 0 = load |
| req_size | input | 3 | Access size code (0..4 = 1..16 bytes) |
| req_addr | input | 32 | Physical byte address |
| req_wdata | input | 128 | Store data, right-aligned |
| busy | output | 1 | Miss in progress, request not accepted |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_hit | output | 1 | Response came from a hit |
| rsp_rdata | output | 128 | Load data, right-aligned, zero-extended |
| mem_valid | output | 1 | Memory beat request |
| mem_write | output | 1 | 1 = writeback beat, 0 = refill beat |
| mem_addr | output | 32 | Beat address (16-byte aligned) |
| mem_wdata | output | 128 | Writeback beat data |
| mem_ready | input | 1 | Memory accepts the beat |
| mem_rdata | input | 128 | Refill beat data, valid with mem_ready |

## Verification
The bench builds the block with its default of 64 sets, so the tag starts at address bit 12. Addresses are confined to sets 0, 5 and 63 plus a random set, with four tags that include the all-ones tag. Three or more tags per set force repeated conflict evictions, so the flag-XOR rotation, writeback of modified victims and index-edge address assembly are all reached within a few hundred accesses. A randomly throttled `mem_ready` exercises beat holding, and random sizes and offsets reach every byte lane of the quadword merge.

// File: rtl/dc_pkg.sv
package dc_pkg;
    localparam int LINE_OFF = 6;
    localparam int BEATS    = 4;
    localparam int BEAT_W   = 2;
    localparam int QW_W     = 128;

    localparam int FLAG_DIRTY = 6;
    localparam int FLAG_VALID = 5;
    localparam int FLAG_LRF   = 4;
    localparam int FLAG_LOCK  = 3;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_EVICT,
        ST_REFILL,
        ST_FINISH
    } dc_state_e;

    typedef struct packed {
        logic            write;
        logic [2:0]      size;
        logic [31:0]     addr;
        logic [QW_W-1:0] wdata;
    } dc_req_t;

    function automatic logic [15:0] size_bytemask(input logic [2:0] s);
        case (s)
            3'd0:    return 16'h0001;
            3'd1:    return 16'h0003;
            3'd2:    return 16'h000F;
            3'd3:    return 16'h00FF;
            default: return 16'hFFFF;
        endcase
    endfunction

    function automatic logic [3:0] align_off(input logic [3:0] off, input logic [2:0] s);
        case (s)
            3'd0:    return off;
            3'd1:    return {off[3:1], 1'b0};
            3'd2:    return {off[3:2], 2'b0};
            3'd3:    return {off[3], 3'b0};
            default: return 4'd0;
        endcase
    endfunction
endpackage

// File: rtl/dc_merge.sv
module dc_merge
    import dc_pkg::*;
(
    input  logic [QW_W-1:0] old_qw,
    input  logic [QW_W-1:0] wdata,
    input  logic [3:0]      off,
    input  logic [2:0]      size,
    output logic [QW_W-1:0] new_qw,
    output logic [QW_W-1:0] rd_data
);
    logic [3:0]      a_off;
    logic [15:0]     lane_mask;
    logic [15:0]     lane_mask_sh;
    logic [QW_W-1:0] wd_sh;
    logic [QW_W-1:0] old_sh;

    always_comb begin
        a_off        = align_off(off, size);
        lane_mask    = size_bytemask(size);
        lane_mask_sh = lane_mask << a_off;
        wd_sh        = wdata << {a_off, 3'b000};
        old_sh       = old_qw >> {a_off, 3'b000};
        for (int b = 0; b < 16; b++) begin
            new_qw[b*8 +: 8]  = lane_mask_sh[b] ? wd_sh[b*8 +: 8] : old_qw[b*8 +: 8];
            rd_data[b*8 +: 8] = lane_mask[b] ? old_sh[b*8 +: 8] : 8'h00;
        end
    end
endmodule

// File: rtl/dc_lookup.sv
module dc_lookup #(
    parameter int TAG_W = 20
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [TAG_W-1:0]      cmp_tag,
    input  logic [1:0][TAG_W-1:0] way_tag,
    input  logic [1:0]            way_valid,
    input  logic [1:0]            way_dirty,
    input  logic [1:0]            way_lrf,
    output logic                  hit,
    output logic                  hit_way,
    output logic                  victim_way,
    output logic                  victim_dirty
);
    logic [1:0] match;

    for (genvar w = 0; w < 2; w++) begin : g_cmp
        assign match[w] = way_valid[w] && (way_tag[w] == cmp_tag);
    end

    assign hit          = |match;
    assign hit_way      = !match[0];
    assign victim_way   = way_lrf[0] ^ way_lrf[1];
    assign victim_dirty = way_valid[victim_way] && way_dirty[victim_way];

    AST_HIT_SINGLE_WAY: assert property (@(posedge clk) disable iff (rst)
        $onehot0(match)); // R1

    AST_DIRTY_IMPLIES_VALID: assert property (@(posedge clk) disable iff (rst)
        (way_dirty & ~way_valid) == 2'b00); // R5
endmodule

// File: rtl/dc_line_ram.sv
module dc_line_ram #(
    parameter int ENT_W = 9,
    parameter int DW    = 128
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [ENT_W-1:0] wr_ent,
    input  logic [DW-1:0]    wr_data,
    input  logic [ENT_W-1:0] ra_ent,
    output logic [DW-1:0]    ra_data,
    input  logic [ENT_W-1:0] rb_ent,
    output logic [DW-1:0]    rb_data
);
    localparam int DEPTH = 1 << ENT_W;

    logic [DW-1:0] store_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) store_q[wr_ent] <= wr_data;
    end

    assign ra_data = store_q[ra_ent];
    assign rb_data = store_q[rb_ent];
endmodule

// File: rtl/dc_two_way_cache.sv
module dc_two_way_cache
    import dc_pkg::*;
#(
    parameter int INDEX_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [2:0]        req_size,
    input  logic [31:0]       req_addr,
    input  logic [QW_W-1:0]   req_wdata,
    output logic              busy,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [QW_W-1:0]   rsp_rdata,
    output logic              mem_valid,
    output logic              mem_write,
    output logic [31:0]       mem_addr,
    output logic [QW_W-1:0]   mem_wdata,
    input  logic              mem_ready,
    input  logic [QW_W-1:0]   mem_rdata
);
    localparam int SETS    = 1 << INDEX_W;
    localparam int TAG_LSB = LINE_OFF + INDEX_W;
    localparam int TAG_W   = 32 - TAG_LSB;
    localparam int ENT_W   = INDEX_W + 1 + BEAT_W;

    dc_state_e           state_q;
    dc_req_t             req_q, cur_req;
    logic                vway_q;
    logic [BEAT_W-1:0]   beat_q;
    logic [31:0]         tag_q [SETS][2];

    logic [INDEX_W-1:0]    cur_set;
    logic [1:0][TAG_W-1:0] way_tag;
    logic [1:0]            way_valid, way_dirty, way_lrf;
    logic                  hit, hit_way, victim_way, victim_dirty;
    logic                  acc_way;
    logic [ENT_W-1:0]      ent_a, ent_b, wr_ent;
    logic [QW_W-1:0]       ra_data, rb_data, new_qw, rd_qw, wr_data;
    logic                  wr_en, store_now, fill_now, last_beat;
    logic [31:0]           victim_word, fill_tag;
    logic [2:0]            eff_size;

    // Current request: live port while idle, captured copy during a miss
    always_comb begin
        if (state_q == ST_IDLE) begin
            cur_req.write = req_write;
            cur_req.size  = req_size;
            cur_req.addr  = req_addr;
            cur_req.wdata = req_wdata;
        end else begin
            cur_req = req_q;
        end
    end

    assign cur_set  = cur_req.addr[TAG_LSB-1:LINE_OFF];
    assign eff_size = (cur_req.size > 3'd4) ? 3'd4 : cur_req.size;

    for (genvar w = 0; w < 2; w++) begin : g_way
        assign way_tag[w]   = tag_q[cur_set][w][31:TAG_LSB];
        assign way_valid[w] = tag_q[cur_set][w][FLAG_VALID];
        assign way_dirty[w] = tag_q[cur_set][w][FLAG_DIRTY];
        assign way_lrf[w]   = tag_q[cur_set][w][FLAG_LRF];
    end

    dc_lookup #(.TAG_W(TAG_W)) u_lookup (
        .clk          (clk),
        .rst          (rst),
        .cmp_tag      (cur_req.addr[31:TAG_LSB]),
        .way_tag      (way_tag),
        .way_valid    (way_valid),
        .way_dirty    (way_dirty),
        .way_lrf      (way_lrf),
        .hit          (hit),
        .hit_way      (hit_way),
        .victim_way   (victim_way),
        .victim_dirty (victim_dirty)
    );

    assign acc_way = (state_q == ST_IDLE) ? hit_way : vway_q;
    assign ent_a   = {cur_set, acc_way, cur_req.addr[5:4]};
    assign ent_b   = {cur_set, vway_q, beat_q};

    dc_merge u_merge (
        .old_qw  (ra_data),
        .wdata   (cur_req.wdata),
        .off     (cur_req.addr[3:0]),
        .size    (eff_size),
        .new_qw  (new_qw),
        .rd_data (rd_qw)
    );

    assign store_now = ((state_q == ST_IDLE) && req_valid && hit && req_write) ||
                       ((state_q == ST_FINISH) && req_q.write);
    assign fill_now  = (state_q == ST_REFILL) && mem_ready;
    assign wr_en     = store_now || fill_now;
    assign wr_ent    = fill_now ? ent_b : ent_a;
    assign wr_data   = fill_now ? mem_rdata : new_qw;

    dc_line_ram #(.ENT_W(ENT_W), .DW(QW_W)) u_ram (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_ent  (wr_ent),
        .wr_data (wr_data),
        .ra_ent  (ent_a),
        .ra_data (ra_data),
        .rb_ent  (ent_b),
        .rb_data (rb_data)
    );

    assign victim_word = tag_q[cur_set][vway_q];
    always_comb begin
        fill_tag              = victim_word;
        fill_tag[31:TAG_LSB]  = req_q.addr[31:TAG_LSB];
        fill_tag[FLAG_VALID]  = 1'b1;
        fill_tag[FLAG_LRF]    = ~victim_word[FLAG_LRF];
    end

    assign last_beat = (beat_q == BEAT_W'(BEATS - 1));
    assign busy      = (state_q != ST_IDLE);
    assign mem_valid = (state_q == ST_EVICT) || (state_q == ST_REFILL);
    assign mem_write = (state_q == ST_EVICT);
    assign mem_wdata = rb_data;
    assign mem_addr  = {(state_q == ST_EVICT) ? victim_word[31:TAG_LSB] : req_q.addr[31:TAG_LSB],
                        cur_set, beat_q, 4'b0000};

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) begin
                tag_q[s][0] <= '0;
                tag_q[s][1] <= '0;
            end
            state_q   <= ST_IDLE;
            req_q     <= '0;
            vway_q    <= 1'b0;
            beat_q    <= '0;
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        if (hit) begin
                            rsp_valid <= 1'b1;
                            rsp_hit   <= 1'b1;
                            rsp_rdata <= req_write ? '0 : rd_qw;
                            if (req_write) tag_q[cur_set][hit_way][FLAG_DIRTY] <= 1'b1;
                        end else begin
                            req_q   <= cur_req;
                            vway_q  <= victim_way;
                            beat_q  <= '0;
                            state_q <= victim_dirty ? ST_EVICT : ST_REFILL;
                        end
                    end
                end
                ST_EVICT: begin
                    if (mem_ready) begin
                        beat_q <= beat_q + 1'b1;
                        if (last_beat) begin
                            tag_q[cur_set][vway_q][FLAG_DIRTY] <= 1'b0;
                            state_q <= ST_REFILL;
                        end
                    end
                end
                ST_REFILL: begin
                    if (mem_ready) begin
                        beat_q <= beat_q + 1'b1;
                        if (last_beat) begin
                            tag_q[cur_set][vway_q] <= fill_tag;
                            state_q <= ST_FINISH;
                        end
                    end
                end
                default: begin
                    rsp_valid <= 1'b1;
                    rsp_hit   <= 1'b0;
                    rsp_rdata <= req_q.write ? '0 : rd_qw;
                    if (req_q.write) tag_q[cur_set][vway_q][FLAG_DIRTY] <= 1'b1;
                    state_q <= ST_IDLE;
                end
            endcase
        end
    end

    AST_IDLE_NO_MEM: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mem_valid); // R7

    AST_BEAT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_write))); // R9

    AST_WB_BEFORE_FILL: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && !mem_write) |=> !(mem_valid && mem_write)); // R3

    AST_RSP_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> rsp_valid); // R7
endmodule

// File: tb/dc_two_way_cache_bench.sv
module dc_two_way_cache_bench;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         req_valid = 1'b0;
    logic         req_write = 1'b0;
    logic [2:0]   req_size = 3'd0;
    logic [31:0]  req_addr = 32'd0;
    logic [127:0] req_wdata = '0;
    logic         busy, rsp_valid, rsp_hit;
    logic [127:0] rsp_rdata;
    logic         mem_valid, mem_write;
    logic [31:0]  mem_addr;
    logic [127:0] mem_wdata;
    logic         mem_ready = 1'b0;
    logic [127:0] mem_rdata;

    always #5 clk = ~clk;

    dc_two_way_cache u_dc_two_way_cache (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_write(req_write), .req_size(req_size),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .busy(busy), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_rdata(rsp_rdata),
        .mem_valid(mem_valid), .mem_write(mem_write), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata)
    );

    int  total = 0;
    int  bad = 0;
    bit  finished = 0;

    logic [127:0] bmem [logic [31:0]];
    logic [127:0] gold [logic [31:0]];

    logic [19:0] mtag  [64][2];
    bit          mval  [64][2];
    bit          mdirty[64][2];
    bit          mlrf  [64][2];

    int          wr_beats = 0;
    int          rd_beats = 0;
    logic [31:0] exp_wb_base = '0;
    logic [31:0] exp_rd_base = '0;
    bit          prev_stall = 0;
    logic [31:0] prev_addr = '0;
    logic        prev_write = 0;

    function automatic logic [127:0] fresh(input logic [31:0] a);
        return {a ^ 32'hA5A5_0F0F, ~a, a * 32'd3 + 32'd11, {a[15:0], a[31:16]}};
    endfunction

    function automatic logic [127:0] bmerge(input logic [127:0] old, input logic [127:0] wd,
                                            input int off, input int sz);
        int nb = 1 << ((sz > 4) ? 4 : sz);
        int a  = off - (off % nb);
        logic [127:0] r = old;
        for (int i = 0; i < nb; i++) r[(a + i) * 8 +: 8] = wd[i * 8 +: 8];
        return r;
    endfunction

    function automatic logic [127:0] bextract(input logic [127:0] old, input int off, input int sz);
        int nb = 1 << ((sz > 4) ? 4 : sz);
        int a  = off - (off % nb);
        logic [127:0] r = '0;
        for (int i = 0; i < nb; i++) r[i * 8 +: 8] = old[(a + i) * 8 +: 8];
        return r;
    endfunction

    always_comb mem_rdata = bmem.exists(mem_addr) ? bmem[mem_addr] : fresh(mem_addr);

    always @(posedge clk) mem_ready <= ($urandom % 4) != 0;

    task automatic check(input bit ok, input string req, input logic [127:0] act,
                         input logic [127:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Memory-side monitor: values are stable at the falling edge and transfer at the next rise
    always @(negedge clk) begin
        if (!rst) begin
            if (prev_stall)
                check(mem_valid && mem_addr == prev_addr && mem_write == prev_write,
                      "R9", {95'd0, mem_valid, mem_addr}, {95'd1, prev_addr});
            prev_stall = mem_valid && !mem_ready;
            prev_addr  = mem_addr;
            prev_write = mem_write;
            if (mem_valid && mem_ready) begin
                if (mem_write) begin
                    check(mem_addr == exp_wb_base + 32'(wr_beats * 16), "R3",
                          {96'd0, mem_addr}, {96'd0, exp_wb_base + 32'(wr_beats * 16)});
                    bmem[mem_addr] = mem_wdata;
                    wr_beats++;
                end else begin
                    check(mem_addr == exp_rd_base + 32'(rd_beats * 16), "R4",
                          {96'd0, mem_addr}, {96'd0, exp_rd_base + 32'(rd_beats * 16)});
                    rd_beats++;
                end
            end
        end
    end

    task automatic do_access(input bit wr, input int sz, input logic [31:0] addr,
                             input logic [127:0] wd);
        int           s = int'(addr[11:6]);
        logic [19:0]  t = addr[31:12];
        logic [31:0]  qa = {addr[31:4], 4'h0};
        bit           exp_hit = 0;
        int           way = 0;
        int           exp_wb = 0;
        int           n = 0;
        logic [127:0] old, exp_rd;

        if (mval[s][0] && mtag[s][0] == t) begin
            exp_hit = 1; way = 0;
        end else if (mval[s][1] && mtag[s][1] == t) begin
            exp_hit = 1; way = 1;
        end else begin
            way = mlrf[s][0] ^ mlrf[s][1];
            exp_wb = (mval[s][way] && mdirty[s][way]) ? 4 : 0;
            exp_wb_base = {mtag[s][way], 6'(s), 6'd0};
            mtag[s][way] = t;
            mval[s][way] = 1;
            mdirty[s][way] = 0;
            mlrf[s][way] = !mlrf[s][way];
        end
        if (wr) mdirty[s][way] = 1;
        exp_rd_base = {t, 6'(s), 6'd0};

        old = gold.exists(qa) ? gold[qa] : fresh(qa);
        if (wr) gold[qa] = bmerge(old, wd, int'(addr[3:0]), sz);
        exp_rd = wr ? '0 : bextract(old, int'(addr[3:0]), sz);

        @(negedge clk);
        while (busy) @(negedge clk);
        wr_beats = 0;
        rd_beats = 0;
        req_valid = 1'b1;
        req_write = wr;
        req_size  = 3'(sz);
        req_addr  = addr;
        req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        if (exp_hit)
            check(rsp_valid && !busy, "R1", {126'd0, rsp_valid, busy}, {126'd0, 2'b10});
        else
            check(busy && !rsp_valid, "R7", {126'd0, rsp_valid, busy}, {126'd0, 2'b01});
        while (!rsp_valid && n < 200) begin
            @(negedge clk);
            check(rsp_valid || busy, "R7", {127'd0, busy}, {127'd0, 1'b1});
            n++;
        end
        check(rsp_valid && !busy, "R7", {126'd0, rsp_valid, busy}, {126'd0, 2'b10});
        check(rsp_hit == exp_hit, exp_hit ? "R1" : "R2", {127'd0, rsp_hit}, {127'd0, exp_hit});
        check(rsp_rdata == exp_rd, wr ? "R5" : "R6", rsp_rdata, exp_rd);
        check(wr_beats == exp_wb, "R3", 128'(wr_beats), 128'(exp_wb));
        check(rd_beats == (exp_hit ? 0 : 4), "R4", 128'(rd_beats), 128'(exp_hit ? 0 : 4));
    endtask

    function automatic logic [127:0] rand_qw();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    initial begin
        logic [19:0] tags [4];
        int          sets [4];
        void'($urandom(32'd7717));
        tags[0] = 20'h00000; tags[1] = 20'h00001; tags[2] = 20'h00002; tags[3] = 20'hFFFFF;
        sets[0] = 0; sets[1] = 5; sets[2] = 63; sets[3] = 0;
        for (int s = 0; s < 64; s++)
            for (int w = 0; w < 2; w++) begin
                mtag[s][w] = '0; mval[s][w] = 0; mdirty[s][w] = 0; mlrf[s][w] = 0;
            end

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R8: quiet outputs after reset
        check(!busy && !rsp_valid && !mem_valid, "R8",
              {125'd0, busy, rsp_valid, mem_valid}, 128'd0);

        // Directed: fill way 0, way 1, hit, dirty eviction, clean eviction (R2, R3, R8)
        do_access(1, 2, {20'h00001, 6'd5, 6'h14}, 128'hDEAD_BEEF);
        do_access(0, 3, {20'h00002, 6'd5, 6'h08}, '0);
        do_access(0, 2, {20'h00001, 6'd5, 6'h14}, '0);
        do_access(0, 4, {20'h00003, 6'd5, 6'h20}, '0);
        do_access(0, 2, {20'h00001, 6'd5, 6'h14}, '0);
        // Index and tag edges, full-width store then byte loads (R5, R6)
        do_access(1, 4, {20'hFFFFF, 6'd63, 6'h30}, 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210);
        do_access(0, 0, {20'hFFFFF, 6'd63, 6'h3F}, '0);
        do_access(0, 1, {20'hFFFFF, 6'd63, 6'h31}, '0);
        do_access(1, 7, {20'hFFFFF, 6'd63, 6'h00}, rand_qw());
        do_access(0, 4, {20'hFFFFF, 6'd63, 6'h00}, '0);

        // Constrained random mix
        for (int k = 0; k < 400; k++) begin
            int          sidx = int'($urandom % 4);
            int          sv = (sidx == 3) ? int'($urandom % 64) : sets[sidx];
            logic [19:0] tv = tags[$urandom % 4];
            int          sz = int'($urandom % 5);
            logic [5:0]  lo = 6'($urandom);
            do_access(($urandom % 2) == 1, sz, {tv, 6'(sv), lo}, rand_qw());
        end

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog R7 actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule